// File: doc/BRIEF.md
# Cascaded Programmable Frequency Divider

This block divides its clock by a programmable ratio N. It does this with a chain of 8-bit presettable up-counter slices. The first slice advances on every clock. Each higher slice advances only when the slice below it reports terminal count, and a slice reports terminal count only while it holds all ones and is itself enabled. The active-low terminal counts of all slices are ORed together into one load strobe. That strobe is low only when the whole chain holds all ones, and it then reloads every slice from its part of the preset word on the same edge.

To program a ratio N, write the preset word as 2^W − N, where W is eight times the number of slices. N may be any value from 2 to 2^W. The `tick_o` output pulses high for one clock once every N clocks. The `half_o` output flips on every tick, so it has a period of 2N and a 50% duty cycle. A change to the preset word is only picked up at the next reload, so a period that is already running finishes at its old length. The external reset is asynchronous and active low, and its release is synchronised through two flops inside the block.

Top module: `cdiv_chain`

## Requirements
- R1: While `arst_n` is low, `count_o` is zero, and both `tick_o` and `half_o` are low.
- R2: When no reload occurs, the lowest 8-bit slice of `count_o` increases by one on every clock.
- R3: A higher slice advances only on an edge where every lower slice holds all ones. It then advances by one, so that `count_o` as a whole moves as a single W-bit binary count.
- R4: `tick_o` is high exactly when every bit of `count_o` is one.
- R5: On the edge that follows a high `tick_o`, every slice reloads at once, and `count_o` takes the value `preset_i` had on that edge. Bits [8k+7:8k] of the preset word go to slice k.
- R6: Ticks are spaced exactly N = 2^W − P clocks apart, where P is the preset used at the reload that starts the period.
- R7: The minimum ratio, with preset 2^W − 2, gives a tick on every second clock.
- R8: The maximum ratio, with preset 0, gives ticks spaced 2^W clocks apart.
- R9: `half_o` inverts on the edge after each tick and holds its value otherwise, which gives a period of 2N.
- R10: A change of `preset_i` between two ticks does not alter the period that is running. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| preset_i | input | 8*STAGES | Reload value, equal to 2^W minus the ratio |
| count_o | output | 8*STAGES | Chain count, slice 0 in the low byte |
| tick_o | output | 1 | One-clock pulse every N clocks (chain terminal count) |
| half_o | output | 1 | Toggle output, period 2N, 50% duty |

## Verification
`count_o` and `tick_o` come out of registers and gates only, so each moves one edge after the state that causes it. The bench samples at the falling edge and predicts each new count from the count and preset it sampled half a cycle earlier. `half_o` must have flipped at the sample that follows a tick. A preset written between ticks is expected to show in `count_o` only at the sample after the next tick, and the length of the following period is measured against that preset. Input changes are made 2 ns after a rising edge, so every sample sees settled values.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int unsigned SLICE_W = 8;
  typedef logic [SLICE_W-1:0] slice_t;
endpackage

// File: rtl/cdiv_slice.sv
module cdiv_slice
  import cdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cnt_en_n,
  input  logic   load_n,
  input  slice_t preset,
  output slice_t q,
  output logic   tc_n
);
  slice_t q_d;
  logic   q_en;

  // Reload has priority over counting and ignores the enable.
  always_comb begin
    q_en = !load_n || !cnt_en_n;
    q_d  = load_n ? slice_t'(q + 1'b1) : preset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  // Terminal count is gated by the enable so that it can feed the next slice.
  assign tc_n = ~((&q) & ~cnt_en_n);

  AST_SLICE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(preset)); // R5
  AST_SLICE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cnt_en_n) |=> q == slice_t'($past(q) + 1'b1)); // R2
  AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en_n) |=> $stable(q)); // R3
endmodule

// File: rtl/cdiv_load_gate.sv
module cdiv_load_gate #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] tc_n,
  output logic         load_n
);
  // The load goes low only when every slice is at terminal count.
  assign load_n = |tc_n;
endmodule

// File: rtl/cdiv_halver.sv
module cdiv_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic half
);
  logic half_d;

  always_comb half_d = half ^ tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half <= 1'b0;
    else        half <= half_d;
  end

  AST_HALF_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> half != $past(half)); // R9
  AST_HALF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(half)); // R9
endmodule

// File: rtl/cdiv_chain.sv
module cdiv_chain
  import cdiv_pkg::*;
#(
  parameter  int unsigned STAGES = 4,
  localparam int unsigned W      = STAGES * SLICE_W
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] count_o,
  output logic         tick_o,
  output logic         half_o
);
  logic [1:0]        rst_sync;
  logic              rst_n;
  logic [STAGES-1:0] tc_n;
  logic [STAGES-1:0] en_n;
  logic              load_n;
  slice_t            q [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= '0;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  for (genvar g = 0; g < STAGES; g++) begin : g_slice
    if (g == 0) begin : g_lsb
      assign en_n[g] = 1'b0;
    end else begin : g_upper
      assign en_n[g] = tc_n[g-1];
    end

    cdiv_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_en_n (en_n[g]),
      .load_n   (load_n),
      .preset   (preset_i[g*SLICE_W +: SLICE_W]),
      .q        (q[g]),
      .tc_n     (tc_n[g])
    );

    assign count_o[g*SLICE_W +: SLICE_W] = q[g];
  end

  cdiv_load_gate #(.N(STAGES)) u_gate (
    .tc_n   (tc_n),
    .load_n (load_n)
  );

  assign tick_o = ~load_n;

  cdiv_halver u_half (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_o),
    .half  (half_o)
  );

  AST_TICK_ONLY_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (&count_o)); // R4
  AST_ALLONES_GIVES_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (&count_o) |-> tick_o); // R4
  AST_CHAIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> count_o == $past(preset_i)); // R5
endmodule

// File: tb/cdiv_chain_tb_top.sv
module cdiv_chain_tb_top;
  localparam int unsigned STAGES = 2;
  localparam int unsigned W      = STAGES * 8;

  logic         clk = 1'b0;
  logic         arst_n;
  logic [W-1:0] preset;
  logic [W-1:0] count;
  logic         tick;
  logic         half;

  always #5 clk = ~clk;

  cdiv_chain #(.STAGES(STAGES)) dut_i (
    .clk      (clk),
    .arst_n   (arst_n),
    .preset_i (preset),
    .count_o  (count),
    .tick_o   (tick),
    .half_o   (half)
  );

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit started = 1'b0;
  bit have_tick = 1'b0;
  bit pre_changed = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] prev_cnt, prev_pre;
  logic prev_tick, half_exp;
  longint cyc = 0, last_tick = 0, exp_period = 0;

  function automatic longint ratio_of(logic [W-1:0] p);
    return (longint'(1) << W) - longint'(p);
  endfunction

  function automatic logic [W-1:0] next_count(logic [W-1:0] c, logic [W-1:0] p);
    return (&c) ? p : W'(c + 1'b1);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Falling-edge scoreboard: predicted from the previous sample.
  always @(negedge clk) begin
    if (running) begin
      if (started) begin
        logic [W-1:0] exp_c;
        string        req;
        exp_c = next_count(prev_cnt, prev_pre);
        req   = (&prev_cnt) ? "R5 reload" : ((&prev_cnt[7:0]) ? "R3 carry" : "R2 step");
        check(count == exp_c, req, longint'(count), longint'(exp_c));
        half_exp = half_exp ^ prev_tick;
        check(half == half_exp, "R9 half", longint'(half), longint'(half_exp));
      end else begin
        half_exp = half;
      end
      check(tick == (&count), "R4 tick", longint'(tick), longint'(&count));
      if (tick) begin
        if (have_tick) begin
          string lbl;
          lbl = (exp_period == 2) ? "R7" :
                (exp_period == (longint'(1) << W)) ? "R8" : "R6";
          if (pre_changed) lbl = {lbl, "/R10"};
          check(cyc - last_tick == exp_period, lbl, cyc - last_tick, exp_period);
        end
        have_tick   = 1'b1;
        last_tick   = cyc;
        exp_period  = ratio_of(preset);
        pre_changed = 1'b0;
      end
      prev_cnt  = count;
      prev_pre  = preset;
      prev_tick = tick;
      started   = 1'b1;
      cyc++;
    end
  end

  task automatic set_preset(logic [W-1:0] p);
    @(posedge clk);
    #2;
    if (p != preset) pre_changed = 1'b1;
    preset = p;
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
  endtask

  initial begin
    arst_n = 1'b0;
    preset = '0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(count == '0, "R1 count", longint'(count), 0);
    check(tick == 1'b0, "R1 tick", longint'(tick), 0);
    check(half == 1'b0, "R1 half", longint'(half), 0);
    @(posedge clk);
    #2 arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 running = 1'b1;

    // Maximum ratio: the first tick comes from reset, the second is measured.
    wait_ticks(1);
    repeat (1000) @(posedge clk);
    set_preset(W'((longint'(1) << W) - 2));   // change mid-period (R10)
    wait_ticks(1);
    wait_ticks(6);                            // minimum ratio (R7)

    set_preset(W'((longint'(1) << W) - 3));
    wait_ticks(4);
    set_preset(W'((longint'(1) << W) - 256)); // slice boundary
    wait_ticks(3);
    set_preset(W'((longint'(1) << W) - 257)); // crosses into upper slice
    wait_ticks(3);

    for (int i = 0; i < 6; i++) begin
      int unsigned n;
      n = $urandom_range(700, 2);
      set_preset(W'((longint'(1) << W) - longint'(n)));
      wait_ticks(3);
    end
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 190000, 0);
    summary();
  end
endmodule